// File: doc/BRIEF.md
# Event-Based PWM Pair

This block drives one pair of pulse-width-modulated outputs, a main output A and a complementary output B, from a free-running period counter. Four programmable event positions set the edges. A rises at the first event. It falls at the second event, or, when the filter source is selected, after a width taken from an external duty word supplied by a control-loop filter. B covers the interval from the third event to the fourth. The spacing between A's falling edge and B's rising edge is the dead time. It may be negative, in which case the outputs overlap. A sample-trigger output pulses once per period at a programmed count. This lets an external converter sample in step with the switching.

Software configures the channel through a simple write port while the enable input is low. It then raises the enable, and counting starts from zero. Period and event writes made while running can be held in shadow copies and applied together at the next period boundary, so a single cycle never mixes old and new edges. All pins are plain control and status pins. The filter duty word is a level input with no handshake and no back-pressure. The block samples it at each period boundary and at any time while disabled, and a value that changes in between is ignored until the next boundary.

Top module: `evpwm_pair`

## Requirements
- R1: The counter runs 0 to P−1 and wraps, where P is the period register (address 0). With the channel enabled, a period therefore lasts P clock cycles. A new period value takes effect at the wrap, or at once while disabled.
- R2: With the filter bit (control register address 6, bit 0) clear, A is high for counts c with ev1 ≤ c < ev2, where ev1 is at address 1 and ev2 at address 2. A is high for ev2−ev1 cycles per period.
- R3: With the filter bit set, A is high for counts ev1 ≤ c < ev1+D, where D is the filter duty word sampled at the period wrap. The ev2 register then has no effect.
- R4: With the filter bit set and D ≥ P, A is high for every cycle of the period.
- R5: B is high for counts ev3 ≤ c < ev4, where ev3 is at address 3 and ev4 at address 4. When ev3 lies below A's falling edge, A and B are both high for the overlapping counts, and the block does not clamp them.
- R6: With the defer bit (control address 6, bit 1) set, period, event and trigger writes made while enabled take effect only at the next wrap. With it clear, event and trigger writes take effect from the next cycle.
- R7: samp_trig is high for exactly one cycle per period, for count c equal to the trigger register (address 5). A trigger value ≥ P yields no pulse.
- R8: While en is low, A, B and samp_trig are low and the counter is held at 0. The outputs are registered, so the first output cycle after en rises reflects count 0, and the cycle after en falls shows all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable; counting runs while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 period, 1–4 events, 5 trigger, 6 control) |
| wr_data | input | W | Register write data |
| filt_duty | input | W | Pulse width from the control filter, in counter ticks |
| pwm_a | output | 1 | Main PWM output |
| pwm_b | output | 1 | Complementary PWM output |
| samp_trig | output | 1 | One-cycle sample-trigger pulse |

## Verification
The main function is tried with a set of event layouts measured over a full steady-state period. These include separated edges, which give positive dead time, and an overlapping layout, which gives negative dead time. They also include a trigger value equal to the period, and filter-mode words below, within and above the period. Counting the high cycles of A, of B and of A∧B separates the event-driven width from the filter-driven width, saturated width from clipped width, and overlap from clamping. Directed tests then write ev2 mid-period under both update policies, which tells deferred loading apart from immediate loading. They also measure trigger spacing against the period, and check the output state on the first cycles after enable rises and falls.

// File: rtl/evpwm_pkg.sv
package evpwm_pkg;
  typedef enum logic [2:0] {
    RA_PERIOD = 3'd0,
    RA_EV1    = 3'd1,
    RA_EV2    = 3'd2,
    RA_EV3    = 3'd3,
    RA_EV4    = 3'd4,
    RA_SAMPLE = 3'd5,
    RA_CTRL   = 3'd6
  } reg_addr_e;

  localparam int CTRL_FILTER_BIT = 0;
  localparam int CTRL_DEFER_BIT  = 1;
  localparam int N_TIMING_REGS   = 6;
  localparam int N_WINDOWS       = 2;
endpackage

// File: rtl/evpwm_regs.sv
module evpwm_regs
  import evpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wrap,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] duty_in,
  output logic [W-1:0] prd,
  output logic [W-1:0] ev1,
  output logic [W-1:0] ev2,
  output logic [W-1:0] ev3,
  output logic [W-1:0] ev4,
  output logic [W-1:0] samp,
  output logic [W-1:0] duty,
  output logic         filter_sel,
  output logic         defer
);
  // Timing registers: a software-facing shadow and an active copy each.
  for (genvar g = 0; g < N_TIMING_REGS; g++) begin : g_treg
    localparam logic [2:0] MY_ADDR   = 3'(g);
    localparam bit         WRAP_ONLY = (g == int'(RA_PERIOD));
    logic [W-1:0] shd_q;
    logic [W-1:0] act_q;
    logic         hit;
    logic         direct;

    assign hit    = wr_en && (wr_addr == MY_ADDR);
    assign direct = !en || (!defer && !WRAP_ONLY);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_q <= '0;
        act_q <= '0;
      end else begin
        if (hit) shd_q <= wr_data;
        if (hit && direct) act_q <= wr_data;
        else if (!en || wrap) act_q <= shd_q;
      end
    end
  end

  assign prd  = g_treg[int'(RA_PERIOD)].act_q;
  assign ev1  = g_treg[int'(RA_EV1)].act_q;
  assign ev2  = g_treg[int'(RA_EV2)].act_q;
  assign ev3  = g_treg[int'(RA_EV3)].act_q;
  assign ev4  = g_treg[int'(RA_EV4)].act_q;
  assign samp = g_treg[int'(RA_SAMPLE)].act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filter_sel <= 1'b0;
      defer      <= 1'b0;
    end else if (wr_en && wr_addr == RA_CTRL) begin
      filter_sel <= wr_data[CTRL_FILTER_BIT];
      defer      <= wr_data[CTRL_DEFER_BIT];
    end
  end

  // Filter word is captured at the boundary so a period never mixes widths.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           duty <= '0;
    else if (!en || wrap) duty <= duty_in;
  end
endmodule

// File: rtl/evpwm_counter.sv
module evpwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] prd,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W:0] nxt;
  logic       last;

  assign nxt  = {1'b0, cnt} + (W+1)'(1);
  assign last = nxt >= {1'b0, prd};
  assign wrap = en && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (last) cnt <= '0;
    else           cnt <= nxt[W-1:0];
  end
endmodule

// File: rtl/evpwm_window.sv
module evpwm_window #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] lo,
  input  logic [W:0]   hi,
  input  logic         full,
  output logic         on
);
  assign on = full || ((cnt >= lo) && ({1'b0, cnt} < hi));
endmodule

// File: rtl/evpwm_pair.sv
module evpwm_pair
  import evpwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] filt_duty,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic         samp_trig
);
  logic [W-1:0] prd_act, ev1_act, ev2_act, ev3_act, ev4_act, samp_act, duty_act;
  logic         filter_sel, defer_q;
  logic [W-1:0] cnt_q;
  logic         wrap;

  evpwm_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .duty_in(filt_duty),
    .prd(prd_act), .ev1(ev1_act), .ev2(ev2_act), .ev3(ev3_act), .ev4(ev4_act),
    .samp(samp_act), .duty(duty_act), .filter_sel(filter_sel), .defer(defer_q)
  );

  evpwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .prd(prd_act), .cnt(cnt_q), .wrap(wrap)
  );

  // Window 0 drives A, window 1 drives B.
  logic [N_WINDOWS-1:0][W-1:0] lo_w;
  logic [N_WINDOWS-1:0][W:0]   hi_w;
  logic [N_WINDOWS-1:0]        full_w;
  logic [N_WINDOWS-1:0]        on_w;
  logic [W:0]                  a_fall;

  assign a_fall    = filter_sel ? ({1'b0, ev1_act} + {1'b0, duty_act}) : {1'b0, ev2_act};
  assign lo_w[0]   = ev1_act;
  assign hi_w[0]   = a_fall;
  assign full_w[0] = filter_sel && (duty_act >= prd_act);
  assign lo_w[1]   = ev3_act;
  assign hi_w[1]   = {1'b0, ev4_act};
  assign full_w[1] = 1'b0;

  for (genvar k = 0; k < N_WINDOWS; k++) begin : g_win
    evpwm_window #(.W(W)) u_win (
      .cnt(cnt_q), .lo(lo_w[k]), .hi(hi_w[k]), .full(full_w[k]), .on(on_w[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_a     <= 1'b0;
      pwm_b     <= 1'b0;
      samp_trig <= 1'b0;
    end else begin
      pwm_a     <= en && on_w[0];
      pwm_b     <= en && on_w[1];
      samp_trig <= en && (cnt_q == samp_act);
    end
  end
endmodule

// File: rtl/evpwm_pair_chk.sv
module evpwm_pair_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         pwm_a,
  input logic         pwm_b,
  input logic         samp_trig,
  input logic [W-1:0] cnt,
  input logic [W-1:0] prd_act,
  input logic [W-1:0] ev2_act,
  input logic [W-1:0] duty_act,
  input logic         defer,
  input logic         filter_sel,
  input logic         wrap
);
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && prd_act != '0) |-> (cnt < prd_act));

  assert_saturate_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && filter_sel && duty_act >= prd_act) |=> pwm_a);

  assert_defer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && defer && !wrap) |=> $stable(ev2_act));

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm_a && !pwm_b && !samp_trig));

  assert_held_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

bind evpwm_pair evpwm_pair_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pwm_a(pwm_a), .pwm_b(pwm_b),
  .samp_trig(samp_trig), .cnt(cnt_q), .prd_act(prd_act), .ev2_act(ev2_act),
  .duty_act(duty_act), .defer(defer_q), .filter_sel(filter_sel), .wrap(wrap)
);

// File: tb/tb_evpwm_pair.sv
module tb_evpwm_pair;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic         wr_en;
  logic [2:0]   wr_addr;
  logic [W-1:0] wr_data;
  logic [W-1:0] filt_duty;
  logic         pwm_a, pwm_b, samp_trig;

  always #4 clk = ~clk;  // 125 MHz

  evpwm_pair #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .filt_duty(filt_duty),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .samp_trig(samp_trig)
  );

  int n_chk = 0;
  int n_fail = 0;

  typedef struct packed {
    logic [15:0] prd, e1, e2, e3, e4, samp, fsel, duty;
    logic [15:0] exp_a, exp_b, exp_t, exp_ov;
  } vec_t;

  // prd e1 e2 e3 e4 samp fsel duty | A B trig overlap (per period)
  localparam vec_t VECS [7] = '{
    '{16'd20, 16'd0, 16'd8,  16'd10, 16'd18, 16'd5,  16'd0, 16'd0,  16'd8,  16'd8,  16'd1, 16'd0},
    '{16'd20, 16'd2, 16'd10, 16'd8,  16'd18, 16'd19, 16'd0, 16'd0,  16'd8,  16'd10, 16'd1, 16'd2},
    '{16'd20, 16'd0, 16'd8,  16'd10, 16'd18, 16'd20, 16'd0, 16'd0,  16'd8,  16'd8,  16'd0, 16'd0},
    '{16'd20, 16'd0, 16'd0,  16'd10, 16'd18, 16'd3,  16'd1, 16'd8,  16'd8,  16'd8,  16'd1, 16'd0},
    '{16'd20, 16'd0, 16'd8,  16'd10, 16'd18, 16'd3,  16'd1, 16'd25, 16'd20, 16'd8,  16'd1, 16'd8},
    '{16'd10, 16'd1, 16'd5,  16'd6,  16'd9,  16'd0,  16'd0, 16'd0,  16'd4,  16'd3,  16'd1, 16'd0},
    '{16'd20, 16'd4, 16'd5,  16'd10, 16'd18, 16'd7,  16'd1, 16'd10, 16'd10, 16'd8,  16'd1, 16'd4}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic config_ch(input int p, input int e1, input int e2, input int e3,
                           input int e4, input int s, input int ctrl, input int d);
    en = 1'b0;
    @(negedge clk);
    filt_duty = W'(d);
    wr(3'd0, p); wr(3'd1, e1); wr(3'd2, e2); wr(3'd3, e3);
    wr(3'd4, e4); wr(3'd5, s); wr(3'd6, ctrl);
  endtask

  task automatic measure(input int p, output int ca, output int cb, output int ct, output int co);
    ca = 0; cb = 0; ct = 0; co = 0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      ca += int'(pwm_a); cb += int'(pwm_b); ct += int'(samp_trig);
      co += int'(pwm_a && pwm_b);
    end
  endtask

  task automatic wait_trig();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!samp_trig && guard < 500);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int ca, cb, ct, co, d;
    rst_n = 1'b0; en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; filt_duty = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset outputs low", int'(pwm_a) + int'(pwm_b) + int'(samp_trig), 0);
    rst_n = 1'b1;

    // Vector walk: steady-state counts over one full period.
    foreach (VECS[i]) begin
      config_ch(int'(VECS[i].prd), int'(VECS[i].e1), int'(VECS[i].e2), int'(VECS[i].e3),
                int'(VECS[i].e4), int'(VECS[i].samp), 2 + int'(VECS[i].fsel), int'(VECS[i].duty));
      en = 1'b1;
      repeat (2 * int'(VECS[i].prd)) @(negedge clk);
      measure(int'(VECS[i].prd), ca, cb, ct, co);
      chk($sformatf("R2 R3 R4 A high count vec %0d", i), ca, int'(VECS[i].exp_a));
      chk($sformatf("R5 B high count vec %0d", i), cb, int'(VECS[i].exp_b));
      chk($sformatf("R7 trigger count vec %0d", i), ct, int'(VECS[i].exp_t));
      chk($sformatf("R5 overlap count vec %0d", i), co, int'(VECS[i].exp_ov));
    end

    // R1: trigger spacing equals the period.
    config_ch(13, 0, 4, 6, 10, 4, 2, 0);
    en = 1'b1;
    wait_trig();
    d = 0;
    do begin
      @(negedge clk);
      d++;
    end while (!samp_trig && d < 100);
    chk("R1 period length in cycles", d, 13);

    // R6 deferred: ev2 written mid-period applies only after the wrap.
    config_ch(20, 0, 8, 10, 18, 0, 2, 0);
    en = 1'b1;
    wait_trig();
    ca = int'(pwm_a);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = W'(14);
    for (int i = 1; i < 20; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      ca += int'(pwm_a);
    end
    chk("R6 deferred write keeps current period", ca, 8);
    measure(20, ca, cb, ct, co);
    chk("R6 deferred write applies next period", ca, 14);

    // R6 immediate: same write lands within the current period.
    wr(3'd6, 0);
    wr(3'd2, 8);
    wait_trig();
    ca = int'(pwm_a);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = W'(14);
    for (int i = 1; i < 20; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      ca += int'(pwm_a);
    end
    chk("R6 immediate write applies mid period", ca, 14);

    // R8: quiet while disabled, count 0 first after enable, low after disable.
    config_ch(20, 0, 8, 10, 18, 0, 2, 0);
    d = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      d += int'(pwm_a) + int'(pwm_b) + int'(samp_trig);
    end
    chk("R8 outputs low while disabled", d, 0);
    en = 1'b1;
    @(negedge clk);
    chk("R8 first cycle A reflects count 0", int'(pwm_a), 1);
    chk("R8 first cycle trigger at count 0", int'(samp_trig), 1);
    repeat (4) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R8 outputs low after disable", int'(pwm_a) + int'(pwm_b) + int'(samp_trig), 0);

    summary();
    $finish;
  end
endmodule